// File: doc/BRIEF.md
# Byte-Lane Asynchronous-Style Memory Core

This block is a synthesizable model of an SRAM-compatible non-volatile word memory. Its control inputs follow the usual active-low scheme: chip enable, write enable, output enable, and one enable per byte lane. The bidirectional data pins of a real device are replaced by a separate data input, data output and output-enable flag per byte lane, so a pad ring or a bus model can attach them as needed. A system clock samples the controls at each rising edge. This keeps the model synthesizable while keeping the decode of the standard truth table.

On every edge the controls are classified into one of nine modes: standby, output disabled, both lanes off, a read of the lower, upper or both lanes, and a write of the lower, upper or both lanes. Writes take priority over output enable. A write stores only the lanes whose enable is low. A read returns registered data one clock later, with a per-lane drive flag. A supply-good input gates every write, so that nothing is stored while the supply is out of range. Reset clears only the output registers. The array contents survive reset, as non-volatile storage would.

The full device uses a 16-bit address, which gives 65,536 sixteen-bit words (1,048,576 bits). The address width is a parameter, so smaller instances cost less storage.

Top module: `byte_lane_mem`

## Requirements
- R1: The array holds 2**ADDR_W words of 2*LANE_W bits. Bits LANE_W-1:0 form the lower lane and the bits above form the upper lane. A full word written to an address reads back unchanged from that address.
- R2: When ce_n is high at an edge, nothing is written, and both lo_oe and hi_oe are low after that edge, whatever the other controls are.
- R3: When ce_n is low and both we_n and oe_n are high at an edge, nothing is written, and both drive flags are low after that edge.
- R4: When ce_n is low and both lb_n and ub_n are high at an edge, nothing is written, and both drive flags are low after that edge, whatever we_n and oe_n are.
- R5: A read (ce_n low, we_n high, oe_n low) sets, one clock later, the drive flag of each lane whose enable is low, and puts that lane's stored byte on its output. A lane that is not read shows a low flag and an all-zero output.
- R6: A write (ce_n low, we_n low, supply_ok high) stores the input byte of each lane whose enable is low at that edge, whatever oe_n is. A lane whose enable is high keeps its previous contents.
- R7: A lane being written at an edge is not driven after that edge, even if oe_n is low.
- R8: While supply_ok is low, no write condition stores anything, and the previous contents stay intact.
- R9: Reset clears both drive flags and both data outputs but leaves the array contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the controls |
| rst_n | input | 1 | Active-low asynchronous reset of the output registers |
| supply_ok | input | 1 | High while the supply is within range; low inhibits writes |
| ce_n | input | 1 | Active-low chip enable |
| we_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable |
| lb_n | input | 1 | Active-low lower lane enable |
| ub_n | input | 1 | Active-low upper lane enable |
| addr | input | ADDR_W | Word address |
| lo_din | input | LANE_W | Lower lane write data |
| hi_din | input | LANE_W | Upper lane write data |
| lo_dout | output | LANE_W | Lower lane registered read data |
| hi_dout | output | LANE_W | Upper lane registered read data |
| lo_oe | output | 1 | Lower lane drive flag |
| hi_oe | output | 1 | Upper lane drive flag |

## Verification
The bench builds the block with ADDR_W = 8 and LANE_W = 8. The full 16-bit depth would add only storage and no new decode behaviour. With the small array, every scenario can read its addresses back after each write attempt, within a short run. The nine truth-table modes, writes dropped while the supply is low, read-after-write drive suppression and memory retention across reset are each reached by a directed task at several addresses with distinct data patterns.

// File: rtl/blm_pkg.sv
package blm_pkg;

  typedef enum logic [3:0] {
    MODE_STANDBY   = 4'd0,
    MODE_OUT_OFF   = 4'd1,
    MODE_LANES_OFF = 4'd2,
    MODE_RD_LO     = 4'd3,
    MODE_RD_HI     = 4'd4,
    MODE_RD_WORD   = 4'd5,
    MODE_WR_LO     = 4'd6,
    MODE_WR_HI     = 4'd7,
    MODE_WR_WORD   = 4'd8
  } blm_mode_e;

  // Whole-pin classification; write wins over output enable.
  function automatic blm_mode_e blm_classify(input logic ce_n, input logic we_n,
                                             input logic oe_n, input logic lb_n,
                                             input logic ub_n);
    blm_mode_e m;
    if (ce_n)                m = MODE_STANDBY;
    else if (lb_n && ub_n)   m = MODE_LANES_OFF;
    else if (!we_n) begin
      if (lb_n)              m = MODE_WR_HI;
      else if (ub_n)         m = MODE_WR_LO;
      else                   m = MODE_WR_WORD;
    end
    else if (oe_n)           m = MODE_OUT_OFF;
    else if (lb_n)           m = MODE_RD_HI;
    else if (ub_n)           m = MODE_RD_LO;
    else                     m = MODE_RD_WORD;
    return m;
  endfunction

  // Per-lane read qualifier.
  function automatic logic blm_lane_read(input logic ce_n, input logic we_n,
                                         input logic oe_n, input logic be_n);
    return !ce_n && we_n && !oe_n && !be_n;
  endfunction

  // Per-lane write qualifier, gated by the supply monitor.
  function automatic logic blm_lane_write(input logic ce_n, input logic we_n,
                                          input logic be_n, input logic ok);
    return !ce_n && !we_n && !be_n && ok;
  endfunction

endpackage

// File: rtl/blm_decode.sv
module blm_decode
  import blm_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             supply_ok,
  input  logic             ce_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [LANES-1:0] be_n,
  output logic [LANES-1:0] lane_rd,
  output logic [LANES-1:0] lane_wr,
  output blm_mode_e        mode
);

  assign mode = blm_classify(ce_n, we_n, oe_n, be_n[0], be_n[LANES-1]);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_rd[g] = blm_lane_read(ce_n, we_n, oe_n, be_n[g]);
    assign lane_wr[g] = blm_lane_write(ce_n, we_n, be_n[g], supply_ok);
  end

endmodule

// File: rtl/blm_lane.sv
module blm_lane #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [LANE_W-1:0] din,
  output logic [LANE_W-1:0] dout,
  output logic              oe
);

  localparam int DEPTH = 1 << ADDR_W;

  // Storage has no reset: contents must persist.
  logic [LANE_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr) store[addr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
      oe   <= 1'b0;
    end else begin
      oe   <= rd;
      dout <= rd ? store[addr] : '0;
    end
  end

  assert_rd_wr_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd && wr));
  assert_rd_drives_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> oe);
  assert_wr_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> !oe);
  assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> (dout == '0));

endmodule

// File: rtl/byte_lane_mem.sv
module byte_lane_mem
  import blm_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              lb_n,
  input  logic              ub_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] lo_din,
  input  logic [LANE_W-1:0] hi_din,
  output logic [LANE_W-1:0] lo_dout,
  output logic [LANE_W-1:0] hi_dout,
  output logic              lo_oe,
  output logic              hi_oe
);

  localparam int LANES = 2;

  logic [LANES-1:0]        be_n;
  logic [LANES-1:0]        dec_rd;
  logic [LANES-1:0]        dec_wr;
  blm_mode_e               dec_mode;
  logic [LANE_W-1:0]       lane_din  [LANES];
  logic [LANE_W-1:0]       lane_dout [LANES];
  logic [LANES-1:0]        lane_oe;

  assign be_n         = {ub_n, lb_n};
  assign lane_din[0]  = lo_din;
  assign lane_din[1]  = hi_din;

  blm_decode #(.LANES(LANES)) u_decode (
    .supply_ok (supply_ok),
    .ce_n      (ce_n),
    .we_n      (we_n),
    .oe_n      (oe_n),
    .be_n      (be_n),
    .lane_rd   (dec_rd),
    .lane_wr   (dec_wr),
    .mode      (dec_mode)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    blm_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
      .clk  (clk),
      .rst_n(rst_n),
      .addr (addr),
      .rd   (dec_rd[g]),
      .wr   (dec_wr[g]),
      .din  (lane_din[g]),
      .dout (lane_dout[g]),
      .oe   (lane_oe[g])
    );
  end

  assign lo_dout = lane_dout[0];
  assign hi_dout = lane_dout[1];
  assign lo_oe   = lane_oe[0];
  assign hi_oe   = lane_oe[1];

  assert_standby_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> (!lo_oe && !hi_oe));
  assert_out_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && we_n && oe_n) |=> (!lo_oe && !hi_oe));
  assert_lanes_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_n && ub_n) |=> (!lo_oe && !hi_oe));
  assert_lv_inhibit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> (dec_wr == '0));
  assert_wr_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_wr != '0) |-> (dec_mode inside {MODE_WR_LO, MODE_WR_HI, MODE_WR_WORD}));
  assert_rd_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_rd != '0) |-> (dec_mode inside {MODE_RD_LO, MODE_RD_HI, MODE_RD_WORD}));

endmodule

// File: tb/byte_lane_mem_tb.sv
module byte_lane_mem_tb;

  localparam int AW = 8;
  localparam int LW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          supply_ok = 1'b1;
  logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, lb_n = 1'b1, ub_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [LW-1:0] lo_din = '0, hi_din = '0;
  logic [LW-1:0] lo_dout, hi_dout;
  logic          lo_oe, hi_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  byte_lane_mem #(.ADDR_W(AW), .LANE_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
    .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .lb_n(lb_n), .ub_n(ub_n),
    .addr(addr), .lo_din(lo_din), .hi_din(hi_din),
    .lo_dout(lo_dout), .hi_dout(hi_dout), .lo_oe(lo_oe), .hi_oe(hi_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock: drive at falling edge, sample 1ns after the rising edge.
  task automatic cyc(input logic c, input logic w, input logic o, input logic l,
                     input logic u, input logic [AW-1:0] a,
                     input logic [LW-1:0] dl, input logic [LW-1:0] dh);
    @(negedge clk);
    ce_n = c; we_n = w; oe_n = o; lb_n = l; ub_n = u;
    addr = a; lo_din = dl; hi_din = dh;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, '0, '0, '0);
  endtask

  task automatic wr_word(input logic [AW-1:0] a, input logic [15:0] d);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, a, d[7:0], d[15:8]);
  endtask

  // Word read then compare flags and data.
  task automatic rd_word_expect(input string req, input logic [AW-1:0] a,
                                input logic [15:0] exp);
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, a, '0, '0);
    check(req, {30'd0, hi_oe, lo_oe}, 32'h3);
    check(req, {16'd0, hi_dout, lo_dout}, {16'd0, exp});
  endtask

  task automatic t_reset();
    check("R9 reset flags", {30'd0, hi_oe, lo_oe}, 32'h0);
    check("R9 reset data", {16'd0, hi_dout, lo_dout}, 32'h0);
  endtask

  task automatic t_word_rw();
    wr_word(8'h05, 16'hA1B2);
    wr_word(8'hFF, 16'h5A3C);
    // R6: write with oe_n low still writes
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h06, 8'h34, 8'h12);
    rd_word_expect("R1 word readback 05", 8'h05, 16'hA1B2);
    rd_word_expect("R1 word readback FF", 8'hFF, 16'h5A3C);
    rd_word_expect("R6 write ignores oe_n", 8'h06, 16'h1234);
  endtask

  task automatic t_byte_reads();
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h06, '0, '0);
    check("R5 lower read flags", {30'd0, hi_oe, lo_oe}, 32'h1);
    check("R5 lower read data", {16'd0, hi_dout, lo_dout}, 32'h0034);
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h06, '0, '0);
    check("R5 upper read flags", {30'd0, hi_oe, lo_oe}, 32'h2);
    check("R5 upper read data", {16'd0, hi_dout, lo_dout}, 32'h1200);
  endtask

  task automatic t_byte_writes();
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h05, 8'hEE, 8'hFF);
    rd_word_expect("R6 lower write keeps upper", 8'h05, 16'hA1EE);
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h05, 8'h00, 8'h77);
    rd_word_expect("R6 upper write keeps lower", 8'h05, 16'h77EE);
  endtask

  task automatic t_standby();
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h05, 8'h11, 8'h22);
    check("R2 standby flags", {30'd0, hi_oe, lo_oe}, 32'h0);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h05, '0, '0);
    check("R2 standby read flags", {30'd0, hi_oe, lo_oe}, 32'h0);
    rd_word_expect("R2 standby no write", 8'h05, 16'h77EE);
  endtask

  task automatic t_out_off();
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h05, 8'h11, 8'h22);
    check("R3 output disabled flags", {30'd0, hi_oe, lo_oe}, 32'h0);
    check("R3 output disabled data", {16'd0, hi_dout, lo_dout}, 32'h0);
    rd_word_expect("R3 output disabled no write", 8'h05, 16'h77EE);
  endtask

  task automatic t_lanes_off();
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h05, 8'h11, 8'h22);
    check("R4 lanes off write flags", {30'd0, hi_oe, lo_oe}, 32'h0);
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'h05, '0, '0);
    check("R4 lanes off read flags", {30'd0, hi_oe, lo_oe}, 32'h0);
    rd_word_expect("R4 lanes off no write", 8'h05, 16'h77EE);
  endtask

  task automatic t_write_quiet();
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h06, '0, '0);
    check("R7 read before write drives", {30'd0, hi_oe, lo_oe}, 32'h3);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h06, 8'h9C, 8'h00);
    check("R7 written lane not driven", {30'd0, hi_oe, lo_oe}, 32'h0);
    rd_word_expect("R7 write landed", 8'h06, 16'h129C);
  endtask

  task automatic t_low_voltage();
    supply_ok = 1'b0;
    wr_word(8'h05, 16'h0F0F);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'hFF, 8'h00, 8'h00);
    supply_ok = 1'b1;
    rd_word_expect("R8 word write inhibited", 8'h05, 16'h77EE);
    rd_word_expect("R8 byte write inhibited", 8'hFF, 16'h5A3C);
    wr_word(8'h05, 16'h0F0F);
    rd_word_expect("R8 write after recovery", 8'h05, 16'h0F0F);
  endtask

  task automatic t_retention();
    rd_word_expect("R9 pre-reset read", 8'hFF, 16'h5A3C);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R9 reset clears flags", {30'd0, hi_oe, lo_oe}, 32'h0);
    check("R9 reset clears data", {16'd0, hi_dout, lo_dout}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    rd_word_expect("R9 contents kept 05", 8'h05, 16'h0F0F);
    rd_word_expect("R9 contents kept FF", 8'hFF, 16'h5A3C);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    idle();
    t_word_rw();
    t_byte_reads();
    t_byte_writes();
    t_standby();
    t_out_off();
    t_lanes_off();
    t_write_quiet();
    t_low_voltage();
    t_retention();
    idle();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule